// File: doc/BRIEF.md
# General-purpose I/O port with phase-timed input synchronizer

This block is a parameterized-width I/O port (8 pins by default) behind a small register bus. A direction register selects, pin by pin, whether the pin is driven. An output-value register supplies the level of driven pins. On pins that are not driven, the same output-value bit turns on a pull-up. The block drives three per-pin pad controls: the output level, the output enable and the pull-up enable.

Every pin's pad level goes through a two-stage input synchronizer before software can read it. The first stage closes on the falling clock edge and holds what the pin showed during the high phase. The second stage copies that held value into the readable pin register on the next rising edge. As a result, an external edge shows up in the pin register after a delay that depends on the clock phase in which it arrived. A value that software writes to the output register can be read back through the pin register one full cycle after the write.

The pad level fed to the synchronizer is worked out inside the block:
- On a driven pin it is the output-value bit.
- On an undriven pin with an external driver present (`pad_drv` = 1) it is that driver's level.
- On an undriven pin with no external driver it is the pull-up state, so it reads 1 with the pull-up on and 0 with it off.

Top module: `gpio_port_sync`

## Requirements
- R1: While `rst_n` is low, the direction and output-value registers are 0x00 and both synchronizer stages are 0. All reads return 0, and `pad_oe` and `pad_pu` are all 0.
- R2: The address map is: 0 is the pin register (read-only), 1 is the direction register, 2 is the output-value register, and 3 reads as 0. A write with `wr_en` = 1 takes effect at the rising edge. `rdata` shows the addressed register combinationally.
- R3: Writes to address 0 or 3 change neither the direction register, nor the output-value register, nor the pin register.
- R4: `pad_oe` equals the direction register. `pad_out` is the output-value bit on pins with direction 1 and is 0 on the other pins. `pad_pu` is 1 exactly where the direction bit is 0 and the output-value bit is 1.
- R5: The sampled pad level is selected as follows:
  - direction 1: the output-value bit;
  - direction 0 with `pad_drv` = 1: the `pad_in` bit;
  - direction 0 with `pad_drv` = 0: the output-value bit, which is the pull-up state.
- R6: A pad level change made during the clock-high phase, before the falling edge, appears in the pin register at the next rising edge. That is half a period after the falling edge.
- R7: A pad level change made during the clock-low phase, after the falling edge, misses that rising edge. It appears in the pin register one full cycle later, about one and a half periods after the change.
- R8: After a write to the output-value register on a driven pin, a pin read in the cycle that immediately follows still returns the old value. The new value is read back from the following cycle on.
- R9: The pin register at each rising edge equals the value the first stage held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data (combinational) |
| pad_in | input | WIDTH | Level from the external driver per pin |
| pad_drv | input | WIDTH | 1 where an external driver is present |
| pad_out | output | WIDTH | Output level per pin |
| pad_oe | output | WIDTH | Output enable per pin |
| pad_pu | output | WIDTH | Pull-up enable per pin |

## Verification
A corrupted direction or output-value register shows on `pad_oe`, `pad_out` and `pad_pu` right after the offending rising edge, and on `rdata` in the same cycle. A wrong first-stage value stays hidden until the next rising edge and then appears in the pin register. A wrong pin register is visible on `rdata` at address 0 immediately. Any bit that slips past its phase window therefore shows up as an extra or a missing cycle of pin latency. The bench exposes this by placing edges just before and just after the falling clock edge.

// File: rtl/gpio_sync_pkg.sv
package gpio_sync_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PIN  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_NONE = 2'd3
  } gpio_sel_e;

  // Level the synchronizer sees on one pin.
  function automatic logic pad_level(input logic dir, input logic outv,
                                     input logic drv, input logic ext);
    logic lvl;
    if (dir)      lvl = outv;
    else if (drv) lvl = ext;
    else          lvl = outv;   // pull-up on -> 1, off -> 0
    return lvl;
  endfunction

  function automatic logic pull_on(input logic dir, input logic outv);
    return !dir && outv;
  endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_sync_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  out_q
);

  logic wr_dir;
  logic wr_out;

  assign wr_dir = wr_en && (gpio_sel_e'(addr) == SEL_DIR);
  assign wr_out = wr_en && (gpio_sel_e'(addr) == SEL_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_out) out_q <= wdata;
    end
  end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_sync_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] out_q,
  input  logic [WIDTH-1:0] pad_in,
  input  logic [WIDTH-1:0] pad_drv,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu,
  output logic [WIDTH-1:0] pad_val
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pad_oe[i]  = dir_q[i];
    assign pad_out[i] = dir_q[i] & out_q[i];
    assign pad_pu[i]  = pull_on(dir_q[i], out_q[i]);
    assign pad_val[i] = pad_level(dir_q[i], out_q[i], pad_drv[i], pad_in[i]);
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_val,
  output logic [WIDTH-1:0] hold_q,
  output logic [WIDTH-1:0] pin_q
);

  // Stage 1: closes at the falling edge. Only its closed value is ever
  // consumed, so it is held by a falling-edge register.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= pad_val;
  end

  // Stage 2: rising-edge register feeding the readable pin register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= hold_q;
  end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_sync_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  pin_q,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  rdata
);

  always_comb begin
    unique case (gpio_sel_e'(addr))
      SEL_PIN: rdata = pin_q;
      SEL_DIR: rdata = dir_q;
      SEL_OUT: rdata = out_q;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync
  import gpio_sync_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pad_in,
  input  logic [WIDTH-1:0]  pad_drv,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pu
);

  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] pad_val;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] pin_q;

  gpio_cfg_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dir_q(dir_q), .out_q(out_q)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .dir_q(dir_q), .out_q(out_q), .pad_in(pad_in), .pad_drv(pad_drv),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_val(pad_val)
  );

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_val(pad_val),
    .hold_q(hold_q), .pin_q(pin_q)
  );

  gpio_rd_mux #(.WIDTH(WIDTH)) u_rd (
    .addr(addr), .pin_q(pin_q), .dir_q(dir_q), .out_q(out_q), .rdata(rdata)
  );

endmodule

// File: rtl/gpio_port_sync_chk.sv
module gpio_port_sync_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] rdata,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_pu,
  input logic [WIDTH-1:0] hold_q,
  input logic [WIDTH-1:0] pin_q
);

  // R1: reset holds everything cleared
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (pad_oe == '0 && pad_pu == '0 && pin_q == '0 && hold_q == '0)
        else $error("p_reset_clear_r1");
    end
  end

  // R4: a pull-up never coexists with an output enable
  always @(negedge clk) begin
    if (rst_n) begin
      p_pu_excl_r4: assert ((pad_pu & pad_oe) == '0) else $error("p_pu_excl_r4");
    end
  end

  // R2/R4: a direction write shows on the output enables next cycle
  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (pad_oe == $past(wdata)));

  // R3: writes to the pin address leave pad controls untouched
  p_pin_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 2'd0 || addr == 2'd3)) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));

  // R9: pin register takes the held first-stage value
  p_pin_from_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin_q == $past(hold_q)));

  // R2: address 3 reads as zero
  p_none_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> (rdata == '0));

endmodule

bind gpio_port_sync gpio_port_sync_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
  .hold_q(hold_q), .pin_q(pin_q)
);

// File: tb/gpio_port_sync_tb.sv
`timescale 1ns/100ps
module gpio_port_sync_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_drv = '0;
  logic [W-1:0] pad_out, pad_oe, pad_pu;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_sync #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_drv(pad_drv),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  // {dir, outv, drv, in, exp_pin, exp_pu, exp_out}
  localparam int NV = 6;
  localparam logic [55:0] VEC [NV] = '{
    {8'h0F, 8'hC3, 8'h00, 8'h00, 8'hC3, 8'hC0, 8'h03},
    {8'h0F, 8'hC3, 8'hF0, 8'hA5, 8'hA3, 8'hC0, 8'h03},
    {8'h00, 8'h00, 8'hFF, 8'h5A, 8'h5A, 8'h00, 8'h00},
    {8'hFF, 8'h96, 8'hFF, 8'h00, 8'h96, 8'h00, 8'h96},
    {8'h00, 8'hFF, 8'h0F, 8'h00, 8'hF0, 8'hFF, 8'h00},
    {8'hAA, 8'h0F, 8'h55, 8'h50, 8'h5A, 8'h05, 8'h0A}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic read_at(input logic [1:0] a, output logic [W-1:0] v);
    addr = a;
    #0.2;
    v = rdata;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] old_pin;
    // R1: reset state
    #12;
    read_at(2'd0, v); check("R1 pin", v, 8'h00);
    read_at(2'd1, v); check("R1 dir", v, 8'h00);
    read_at(2'd2, v); check("R1 outv", v, 8'h00);
    check("R1 oe", pad_oe, 8'h00);
    check("R1 pu", pad_pu, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R4 R5: vector table
    for (int i = 0; i < NV; i++) begin
      bus_write(2'd1, VEC[i][55:48]);
      bus_write(2'd2, VEC[i][47:40]);
      pad_drv = VEC[i][39:32];
      pad_in  = VEC[i][31:24];
      repeat (3) @(posedge clk);
      #1;
      read_at(2'd0, v); check($sformatf("R5 pin v%0d", i), v, VEC[i][23:16]);
      check($sformatf("R4 pu v%0d", i), pad_pu, VEC[i][15:8]);
      check($sformatf("R4 out v%0d", i), pad_out, VEC[i][7:0]);
      check($sformatf("R4 oe v%0d", i), pad_oe, VEC[i][55:48]);
      read_at(2'd1, v); check($sformatf("R2 dir v%0d", i), v, VEC[i][55:48]);
      read_at(2'd2, v); check($sformatf("R2 outv v%0d", i), v, VEC[i][47:40]);
    end

    // R3: writes to pin and unused addresses are ignored
    read_at(2'd0, old_pin);
    bus_write(2'd0, 8'h3C);
    bus_write(2'd3, 8'hE7);
    repeat (2) @(posedge clk); #1;
    read_at(2'd1, v); check("R3 dir kept", v, 8'hAA);
    read_at(2'd2, v); check("R3 outv kept", v, 8'h0F);
    read_at(2'd0, v); check("R3 pin kept", v, old_pin);
    read_at(2'd3, v); check("R2 addr3 zero", v, 8'h00);

    // R6 / R7: input latency by phase
    bus_write(2'd1, 8'h00);
    bus_write(2'd2, 8'h00);
    pad_drv = 8'hFF; pad_in = 8'h00;
    addr = 2'd0;
    repeat (3) @(posedge clk);
    @(posedge clk); #2.0;            // high phase, before falling edge
    pad_in = 8'hFF;
    #2.5; check("R6 before rise", rdata, 8'h00);
    #1.5; check("R6 half period", rdata, 8'hFF);
    @(posedge clk); #3.0;            // low phase, after falling edge
    pad_in = 8'h00;
    #3.0; check("R7 first rise missed", rdata, 8'hFF);
    #5.0; check("R7 one and a half", rdata, 8'h00);

    // R8: software write readback needs one idle cycle
    pad_drv = 8'h00;
    bus_write(2'd1, 8'hFF);
    repeat (3) @(posedge clk); #1;
    read_at(2'd0, v); check("R8 start", v, 8'h00);
    bus_write(2'd2, 8'hFF);
    read_at(2'd0, v); check("R8 immediate old", v, 8'h00);
    @(posedge clk); #1;
    read_at(2'd0, v); check("R8 next cycle new", v, 8'hFF);

    // R1: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    #1;
    read_at(2'd1, v); check("R1 re-reset dir", v, 8'h00);
    read_at(2'd0, v); check("R1 re-reset pin", v, 8'h00);
    check("R1 re-reset oe", pad_oe, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule